// File: doc/BRIEF.md
# MMIO Address to Partition Mapper

This block resolves which isolation partition owns an incoming memory-mapped I/O address. It holds a small table of address windows. Each window is a naturally aligned power-of-two range, described by a base and a mask. A lookup returns a hit flag and an 8-bit partition number. Lookups are pipelined, so a new address can be accepted on every clock.

Each window is programmed with one of four mapping modes:
- **Index mode:** the range is cut into 256 equal segments, and segment n belongs to partition n.
- **Single mode:** the whole range goes to one programmed partition.
- **Slot mode:** the range is cut into 8 segments, and each segment reads its partition from a writable slot table.
- **Offset mode:** the range is cut into 8, 64 or 128 segments, and segment n belongs to partition n plus a programmed base.

Configuration writes are checked for legality as they land. A write that fails the check leaves the window disabled.

Top module: `mmio_pe_mapper`

## Requirements
- R1: After reset every window is disabled, `lk_vld_o` and `lk_hit_o` are low, and a lookup misses.
- R2: An enabled window hits when `(addr & mask) == base`. A window written with `cfg_en_i` low never hits. A window write is rejected (entry left disabled) when the inverted mask is not a run of low ones, or when the base has bits set below the mask.
- R3: Mode code 0 (index) splits the window into 256 equal segments, and an address in segment n returns partition n.
- R4: Mode code 1 (single) returns the programmed partition `cfg_pe_i` for the whole window. The write is rejected when the window is smaller than 32 MB (2^25 bytes).
- R5: Mode code 2 (slot) splits the window into 8 segments. Segment n returns the value held in slot n of that window, written with `cfg_tab_i` high, slot number on `cfg_slot_i`, value on `cfg_pe_i`.
- R6: Mode code 3 (offset) uses `cfg_oseg_i` 0/1/2 for 8/64/128 segments and returns n + `cfg_pe_i` for segment n. The write is rejected when `cfg_oseg_i` is 3 or when the base partition is not a multiple of the segment count.
- R7: When several enabled windows hit, the lowest-numbered window supplies the result.
- R8: On a miss `lk_hit_o` is low and `lk_pe_o` is zero.
- R9: A lookup presented before clock edge k is reported on the outputs after edge k+1, with `lk_vld_o` high. Back-to-back lookups give one result per cycle.
- R10: In any split mode, a window write whose size in bytes is below its segment count is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_tab_i | input | 1 | 1: write a segment slot; 0: write a window entry |
| cfg_idx_i | input | 4 | Window number |
| cfg_slot_i | input | 3 | Slot number for slot writes |
| cfg_base_i | input | 64 | Window base address |
| cfg_mask_i | input | 64 | Window address mask |
| cfg_mode_i | input | 2 | Mapping mode code |
| cfg_en_i | input | 1 | Window enable |
| cfg_pe_i | input | 8 | Partition (single), base partition (offset) or slot value |
| cfg_oseg_i | input | 2 | Offset-mode segment count code |
| lk_vld_i | input | 1 | Lookup request |
| lk_addr_i | input | 64 | Lookup address |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Address owned by a window |
| lk_pe_o | output | 8 | Owning partition |

## Verification
The bench builds the block with its defaults:
- 16 windows, 8 slots per slot-mode window, 64-bit addresses and 8-bit partitions.
- The 32 MB single-window floor, so 2^24 and 2^25 window sizes sit on either side of that rule.

Random windows span sizes from 2^4 to 2^43 bytes. This range lets the small-window rejection, the offset alignment rule and the overlapping-window priority all arise alongside directed cases. Streams of back-to-back lookups check the two-cycle pipeline at full rate.

// File: rtl/mmio_pe_pkg.sv
package mmio_pe_pkg;
  parameter int ADDR_W = 64;
  parameter int PE_W   = 8;
  parameter int SZ_W   = 7;

  typedef enum logic [1:0] {
    MODE_SEG    = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_PROG   = 2'd2,
    MODE_OFFS   = 2'd3
  } win_mode_e;

  typedef struct packed {
    logic              en;
    win_mode_e         mode;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] inv;   // ~mask: offset bits inside window
    logic [SZ_W-1:0]   shift; // log2(segment size)
    logic [PE_W-1:0]   pe;
  } win_ent_t;
endpackage

// File: rtl/mmio_pe_win_cfg.sv
module mmio_pe_win_cfg
  import mmio_pe_pkg::*;
#(
  parameter int NUM_WIN         = 16,
  parameter int PROG_LOG2       = 3,
  parameter int MIN_SINGLE_LOG2 = 25,
  localparam int IDX_W          = $clog2(NUM_WIN)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [ADDR_W-1:0]           base_i,
  input  logic [ADDR_W-1:0]           mask_i,
  input  logic [1:0]                  mode_i,
  input  logic                        en_i,
  input  logic [PE_W-1:0]             pe_i,
  input  logic [1:0]                  oseg_i,
  output win_ent_t [NUM_WIN-1:0]      ent_o
);
  win_ent_t [NUM_WIN-1:0] ent_q;
  win_mode_e         mode;
  logic [ADDR_W-1:0] inv;
  logic [SZ_W-1:0]   sz, segl;
  logic [PE_W-1:0]   offs_msk;
  logic              contig, aligned, size_ok, mode_ok, legal;
  win_ent_t          nxt;

  always_comb begin
    mode     = win_mode_e'(mode_i);
    inv      = ~mask_i;
    contig   = ((inv & (inv + 1'b1)) == '0);
    aligned  = ((base_i & inv) == '0);
    sz       = SZ_W'($countones(inv));
    unique case (mode)
      MODE_SEG:    segl = SZ_W'(PE_W);
      MODE_SINGLE: segl = '0;
      MODE_PROG:   segl = SZ_W'(PROG_LOG2);
      default: case (oseg_i)
        2'd0:    segl = SZ_W'(3);
        2'd1:    segl = SZ_W'(6);
        2'd2:    segl = SZ_W'(7);
        default: segl = '0;
      endcase
    endcase
    offs_msk = PE_W'((32'd1 << segl) - 32'd1);
    size_ok  = (sz >= segl);
    unique case (mode)
      MODE_SINGLE: mode_ok = (sz >= SZ_W'(MIN_SINGLE_LOG2));
      MODE_OFFS:   mode_ok = (oseg_i != 2'd3) && ((pe_i & offs_msk) == '0);
      default:     mode_ok = 1'b1;
    endcase
    legal     = contig && aligned && size_ok && mode_ok;
    nxt.en    = en_i && legal;
    nxt.mode  = mode;
    nxt.base  = base_i;
    nxt.inv   = inv;
    nxt.shift = sz - segl;
    nxt.pe    = pe_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (we_i) begin
      for (int w = 0; w < NUM_WIN; w++)
        if (idx_i == IDX_W'(w)) ent_q[w] <= nxt;
    end
  end

  assign ent_o = ent_q;

  assert_single_small_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && mode_i == 2'd1 && mask_i[MIN_SINGLE_LOG2-1:0] != '0
    |=> !ent_o[$past(idx_i)].en);

  assert_offs_bad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && mode_i == 2'd3 && (oseg_i == 2'd3 || (oseg_i == 2'd0 && pe_i[2:0] != '0))
    |=> !ent_o[$past(idx_i)].en);

  assert_mask_shape_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (((~mask_i) & ((~mask_i) + 1'b1)) != '0)
    |=> !ent_o[$past(idx_i)].en);
endmodule

// File: rtl/mmio_pe_seg_tab.sv
module mmio_pe_seg_tab
  import mmio_pe_pkg::*;
#(
  parameter int NUM_WIN   = 16,
  parameter int PROG_SEGS = 8,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int SLOT_W   = $clog2(PROG_SEGS),
  localparam int DEPTH    = 1 << (IDX_W + SLOT_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PE_W-1:0]   pe_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [SLOT_W-1:0] rd_slot_i,
  output logic [PE_W-1:0]   rd_pe_o
);
  logic [PE_W-1:0] tab_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tab_q[i] <= '0;
    end else if (we_i) begin
      tab_q[{idx_i, slot_i}] <= pe_i;
    end
  end

  assign rd_pe_o = tab_q[{rd_idx_i, rd_slot_i}];
endmodule

// File: rtl/mmio_pe_match.sv
module mmio_pe_match
  import mmio_pe_pkg::*;
#(
  parameter int NUM_WIN = 16,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           vld_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [NUM_WIN-1:0]             en_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] base_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] inv_i,
  input  logic [NUM_WIN-1:0][SZ_W-1:0]   shift_i,
  output logic                           s1_vld_o,
  output logic                           s1_hit_o,
  output logic [IDX_W-1:0]               s1_idx_o,
  output logic [PE_W-1:0]                s1_seg_o
);
  logic [NUM_WIN-1:0]           hit_v;
  logic [NUM_WIN-1:0][PE_W-1:0] seg_v;
  logic [IDX_W-1:0]             sel;
  logic                         any;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hit_v[w] = en_i[w] && ((addr_i & ~inv_i[w]) == base_i[w]);
    assign seg_v[w] = PE_W'((addr_i & inv_i[w]) >> shift_i[w]);
  end

  // lowest index wins
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int w = NUM_WIN - 1; w >= 0; w--)
      if (hit_v[w]) begin
        sel = IDX_W'(w);
        any = 1'b1;
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_o <= 1'b0;
      s1_hit_o <= 1'b0;
      s1_idx_o <= '0;
      s1_seg_o <= '0;
    end else begin
      s1_vld_o <= vld_i;
      s1_hit_o <= vld_i && any;
      s1_idx_o <= sel;
      s1_seg_o <= seg_v[sel];
    end
  end

  assert_prio_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && hit_v[0] |=> s1_hit_o && s1_idx_o == '0);
endmodule

// File: rtl/mmio_pe_mapper.sv
module mmio_pe_mapper
  import mmio_pe_pkg::*;
#(
  parameter int NUM_WIN         = 16,
  parameter int PROG_SEGS       = 8,
  parameter int MIN_SINGLE_LOG2 = 25,
  localparam int IDX_W          = $clog2(NUM_WIN),
  localparam int SLOT_W         = $clog2(PROG_SEGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_tab_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [SLOT_W-1:0] cfg_slot_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_en_i,
  input  logic [PE_W-1:0]   cfg_pe_i,
  input  logic [1:0]        cfg_oseg_i,
  input  logic              lk_vld_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_vld_o,
  output logic              lk_hit_o,
  output logic [PE_W-1:0]   lk_pe_o
);
  win_ent_t [NUM_WIN-1:0]           ent;
  logic [NUM_WIN-1:0]               en_v;
  logic [NUM_WIN-1:0][ADDR_W-1:0]   base_v, inv_v;
  logic [NUM_WIN-1:0][SZ_W-1:0]     shift_v;
  logic                             s1_vld, s1_hit;
  logic [IDX_W-1:0]                 s1_idx;
  logic [PE_W-1:0]                  s1_seg, slot_pe, pe_nxt;
  win_ent_t                         cur;

  mmio_pe_win_cfg #(
    .NUM_WIN(NUM_WIN), .PROG_LOG2(SLOT_W), .MIN_SINGLE_LOG2(MIN_SINGLE_LOG2)
  ) u_win_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && !cfg_tab_i), .idx_i(cfg_idx_i),
    .base_i(cfg_base_i), .mask_i(cfg_mask_i), .mode_i(cfg_mode_i),
    .en_i(cfg_en_i), .pe_i(cfg_pe_i), .oseg_i(cfg_oseg_i),
    .ent_o(ent)
  );

  mmio_pe_seg_tab #(.NUM_WIN(NUM_WIN), .PROG_SEGS(PROG_SEGS)) u_seg_tab (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && cfg_tab_i), .idx_i(cfg_idx_i), .slot_i(cfg_slot_i),
    .pe_i(cfg_pe_i), .rd_idx_i(s1_idx), .rd_slot_i(s1_seg[SLOT_W-1:0]),
    .rd_pe_o(slot_pe)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_unpack
    assign en_v[w]    = ent[w].en;
    assign base_v[w]  = ent[w].base;
    assign inv_v[w]   = ent[w].inv;
    assign shift_v[w] = ent[w].shift;
  end

  mmio_pe_match #(.NUM_WIN(NUM_WIN)) u_match (
    .clk_i, .rst_ni,
    .vld_i(lk_vld_i), .addr_i(lk_addr_i),
    .en_i(en_v), .base_i(base_v), .inv_i(inv_v), .shift_i(shift_v),
    .s1_vld_o(s1_vld), .s1_hit_o(s1_hit), .s1_idx_o(s1_idx), .s1_seg_o(s1_seg)
  );

  always_comb begin
    cur = ent[s1_idx];
    unique case (cur.mode)
      MODE_SEG:    pe_nxt = s1_seg;
      MODE_SINGLE: pe_nxt = cur.pe;
      MODE_PROG:   pe_nxt = slot_pe;
      default:     pe_nxt = cur.pe + s1_seg;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_vld_o <= 1'b0;
      lk_hit_o <= 1'b0;
      lk_pe_o  <= '0;
    end else begin
      lk_vld_o <= s1_vld;
      lk_hit_o <= s1_vld && s1_hit;
      lk_pe_o  <= (s1_vld && s1_hit) ? pe_nxt : '0;
    end
  end

  assert_miss_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_pe_o == '0);
  assert_hit_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_vld_o);
  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_vld_i |=> ##1 lk_vld_o);
  assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld |=> !lk_vld_o);
endmodule

// File: tb/mmio_pe_mapper_bench.sv
module mmio_pe_mapper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int NS = 200;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 0, cfg_tab_i = 0, cfg_en_i = 0;
  logic [3:0]  cfg_idx_i = '0;
  logic [2:0]  cfg_slot_i = '0;
  logic [63:0] cfg_base_i = '0, cfg_mask_i = '0, lk_addr_i = '0;
  logic [1:0]  cfg_mode_i = '0, cfg_oseg_i = '0;
  logic [7:0]  cfg_pe_i = '0;
  logic        lk_vld_i = 0;
  logic        lk_vld_o, lk_hit_o;
  logic [7:0]  lk_pe_o;

  int checks = 0, failures = 0;
  bit done = 0;

  logic        m_en [NW];
  int          m_mode [NW], m_sz [NW], m_segl [NW];
  logic [63:0] m_base [NW], m_mask [NW];
  logic [7:0]  m_pe [NW];
  logic [7:0]  m_slot [NW][8];
  logic        e_hit [NS];
  logic [7:0]  e_pe [NS];

  mmio_pe_mapper u_mmio_pe_mapper (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic bit legal(logic [63:0] b, logic [63:0] m, int mode, int oc,
                               logic [7:0] pe, output int sz, output int segl);
    logic [63:0] inv = ~m;
    bit ok;
    sz = $countones(inv);
    segl = (mode == 0) ? 8 : (mode == 1) ? 0 : (mode == 2) ? 3 :
           (oc == 0) ? 3 : (oc == 1) ? 6 : (oc == 2) ? 7 : 0;
    ok = ((inv & (inv + 1)) == 0) && ((b & inv) == 0) && (sz >= segl);
    if (mode == 1) ok = ok && (sz >= 25);
    if (mode == 3) ok = ok && (oc != 3) && ((int'(pe) % (1 << segl)) == 0);
    return ok;
  endfunction

  task automatic win_wr(int idx, logic [63:0] b, logic [63:0] m, int mode,
                        bit en, logic [7:0] pe, int oc);
    int sz, segl;
    bit ok = legal(b, m, mode, oc, pe, sz, segl);
    m_en[idx] = en && ok; m_mode[idx] = mode; m_base[idx] = b; m_mask[idx] = m;
    m_pe[idx] = pe; m_sz[idx] = sz; m_segl[idx] = segl;
    @(negedge clk_i);
    cfg_we_i = 1; cfg_tab_i = 0; cfg_idx_i = 4'(idx); cfg_base_i = b; cfg_mask_i = m;
    cfg_mode_i = 2'(mode); cfg_en_i = en; cfg_pe_i = pe; cfg_oseg_i = 2'(oc);
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic slot_wr(int idx, int slot, logic [7:0] pe);
    m_slot[idx][slot] = pe;
    @(negedge clk_i);
    cfg_we_i = 1; cfg_tab_i = 1; cfg_idx_i = 4'(idx); cfg_slot_i = 3'(slot); cfg_pe_i = pe;
    @(negedge clk_i);
    cfg_we_i = 0; cfg_tab_i = 0;
  endtask

  function automatic void ref_lk(logic [63:0] a, output logic h, output logic [7:0] p);
    int win = 0;
    logic [63:0] n;
    h = 0; p = 0;
    for (int w = NW - 1; w >= 0; w--)
      if (m_en[w] && ((a & m_mask[w]) == m_base[w])) begin h = 1; win = w; end
    if (!h) return;
    n = (a & ~m_mask[win]) >> (m_sz[win] - m_segl[win]);
    case (m_mode[win])
      0: p = n[7:0];
      1: p = m_pe[win];
      2: p = m_slot[win][n[2:0]];
      default: p = m_pe[win] + n[7:0];
    endcase
  endfunction

  task automatic lk_one(string tag, logic [63:0] a, logic eh, logic [7:0] ep);
    @(negedge clk_i); lk_vld_i = 1; lk_addr_i = a;
    @(negedge clk_i); lk_vld_i = 0;
    @(negedge clk_i);
    chk({tag, " valid"}, 64'(lk_vld_o), 64'd1);
    chk({tag, " hit"}, 64'(lk_hit_o), 64'(eh));
    chk({tag, " pe"}, 64'(lk_pe_o), 64'(ep));
  endtask

  task automatic stream();
    for (int i = 0; i < NS + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        chk("R9 stream valid", 64'(lk_vld_o), 64'd1);
        chk("R9 stream hit", 64'(lk_hit_o), 64'(e_hit[i-2]));
        chk("R9 stream pe", 64'(lk_pe_o), 64'(e_pe[i-2]));
      end
      if (i < NS) begin
        int w = $urandom % NW;
        logic [63:0] a = {$urandom, $urandom};
        if ($urandom % 4 != 0) a = m_base[w] | (a & ~m_mask[w]);
        lk_vld_i = 1; lk_addr_i = a;
        ref_lk(a, e_hit[i], e_pe[i]);
      end else begin
        lk_vld_i = 0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int w = 0; w < NW; w++) begin
      m_en[w] = 0; m_mode[w] = 0; m_sz[w] = 0; m_segl[w] = 0;
      m_base[w] = 0; m_mask[w] = 0; m_pe[w] = 0;
      for (int s = 0; s < 8; s++) m_slot[w][s] = 0;
    end
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", 64'(lk_vld_o), 64'd0);
    chk("R1 reset hit", 64'(lk_hit_o), 64'd0);
    rst_ni = 1;
    lk_one("R1 R8 empty table", 64'h0, 0, 8'd0);

    // R3 index mode, 4 GB window
    win_wr(0, 64'h1_0000_0000, ~64'hFFFF_FFFF, 0, 1, 8'd0, 0);
    lk_one("R3 seg 37", 64'h1_0000_0000 + 64'd37 * 64'h100_0000, 1, 8'd37);
    lk_one("R3 last seg", 64'h1_FFFF_FFFF, 1, 8'd255);

    // R4 single mode floor
    win_wr(1, 64'h200_0000_0000, ~64'hFF_FFFF, 1, 1, 8'd9, 0);
    lk_one("R4 16MB rejected", 64'h200_0000_0010, 0, 8'd0);
    win_wr(1, 64'h200_0000_0000, ~64'h1FF_FFFF, 1, 1, 8'd9, 0);
    lk_one("R4 32MB accepted", 64'h200_01FF_0000, 1, 8'd9);

    // R5 slot mode
    win_wr(2, 64'h3000_0000, ~64'hF_FFFF, 2, 1, 8'd0, 0);
    slot_wr(2, 5, 8'hAB);
    lk_one("R5 slot 5", 64'h3000_0000 + 64'd5 * 64'h2_0000 + 64'h44, 1, 8'hAB);

    // R6 offset mode
    win_wr(3, 64'h4000_0000, ~64'hFFF_FFFF, 3, 1, 8'd4, 0);
    lk_one("R6 base 4 of 8 rejected", 64'h4000_0000, 0, 8'd0);
    win_wr(3, 64'h4000_0000, ~64'hFFF_FFFF, 3, 1, 8'd128, 3);
    lk_one("R6 code 3 rejected", 64'h4000_0000, 0, 8'd0);
    win_wr(3, 64'h4000_0000, ~64'hFFF_FFFF, 3, 1, 8'd128, 2);
    lk_one("R6 seg 3 plus 128", 64'h4000_0000 + 64'd3 * 64'h20_0000, 1, 8'd131);

    // R7 overlap priority
    win_wr(4, 64'h0, ~64'h1FF_FFFF, 1, 1, 8'd1, 0);
    win_wr(5, 64'h0, ~64'h3FF_FFFF, 1, 1, 8'd2, 0);
    lk_one("R7 low wins", 64'h100, 1, 8'd1);
    lk_one("R7 outer only", 64'h300_0000, 1, 8'd2);

    // R2 disable, mask shape
    win_wr(4, 64'h0, ~64'h1FF_FFFF, 1, 0, 8'd1, 0);
    lk_one("R2 disabled entry", 64'h100, 1, 8'd2);
    win_wr(6, 64'h5000_0000, 64'hFFFF_FFFF_FF0F_FFFF, 0, 1, 8'd0, 0);
    lk_one("R2 bad mask rejected", 64'h5000_0000, 0, 8'd0);
    win_wr(6, 64'h5000_0010, ~64'hFFFF, 0, 1, 8'd0, 0);
    lk_one("R2 misaligned rejected", 64'h5000_0010, 0, 8'd0);

    // R10 window below segment count
    win_wr(7, 64'h6000_0000, ~64'hF, 0, 1, 8'd0, 0);
    lk_one("R10 tiny split rejected", 64'h6000_0003, 0, 8'd0);
    lk_one("R8 miss", 64'h7777_0000_0000, 0, 8'd0);

    stream();
    for (int r = 0; r < 4; r++) begin
      for (int w = 0; w < NW; w++) begin
        int sz = 4 + $urandom % 40;
        logic [63:0] m = ~((64'd1 << sz) - 1);
        logic [63:0] b = {16'h0, $urandom, 16'(($urandom))} & m;
        int oc = $urandom % 4;
        logic [7:0] pe = 8'($urandom);
        if ($urandom % 2 == 0 && oc != 3) pe = pe & ~8'((1 << (oc == 0 ? 3 : oc == 1 ? 6 : 7)) - 1);
        win_wr(w, b, m, $urandom % 4, ($urandom % 8) != 0, pe, oc);
        for (int s = 0; s < 8; s++) slot_wr(w, s, 8'($urandom));
      end
      stream();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule